// File: doc/BRIEF.md
# Custom Instruction Configuration Sequencer

This block sits in the decode stage of a core that carries a run-time programmable specialized functional unit. It takes a two-word custom instruction and splits it into its parts. The first word gives the opcode, a 10-bit instruction identifier, the addressing mode and two destination registers. The second word gives four 8-bit source fields. Each source field is either a register number or an immediate, depending on the addressing mode.

When the opcode matches the custom-instruction opcode, the block looks up the identifier in a small internal configuration store. It then plays back one to four 62-bit configuration words to the functional unit, one word per clock. During playback it raises `busy`. After the last word it pulses `done`. Any other opcode is latched and passed through with a flag that marks it as not custom, and no playback follows.

The configuration store is loaded through its own write port. The port can write one configuration word for an (identifier, step) pair, or the step count for an identifier. Store contents are not cleared by reset.

Top module: `ci_seq_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, and after that edge, `busy`, `done`, `dec_valid` and `dec_not_custom` are 0 and `cfg_word` is zero. A reset during playback abandons the playback.
- R2: An instruction is accepted at a rising edge where `ins_valid` is high and `busy` is low. After that edge, `dec_valid` is high for exactly one cycle. The decode outputs hold the fields of `ins_word0` until the next acceptance: opcode at bits 31:24, identifier at 23:14, addressing mode at 13:12, first destination at 11:8 and second destination at 3:0. `dec_raw` holds the whole of `ins_word0`.
- R3: Source n (n = 1..4) is taken from `ins_word1` bits [39-8n : 32-8n], so source 1 sits at 31:24. Mode m (0..3) makes the last m sources immediates, and `dec_imm_mask` bit n-1 is set for each immediate source. A register source puts its low 4 bits on `dec_rs[4(n-1)+:4]` and zero on `dec_imm[32(n-1)+:32]`. An immediate source puts its 8 bits, zero-extended, on `dec_imm` and zero on `dec_rs`.
- R4: A custom instruction whose stored step count is L (0..3) plays back L+1 steps. In cycle k after the acceptance edge (k = 0..L), `cfg_step` equals k and `cfg_word` equals the stored word for step k.
- R5: `busy` is high in exactly the playback cycles. `done` is high for exactly one cycle, the one after the last step.
- R6: An instruction presented while `busy` is high is ignored. `dec_valid` stays low, the decode outputs keep their values and playback continues unchanged.
- R7: An accepted instruction whose opcode is not `CI_OPCODE` sets `dec_not_custom`, passes its word through on `dec_raw` and starts no playback.
- R8: An instruction presented in the `done` cycle is accepted at the next edge and begins playback at once.
- R9: A write to the store becomes visible from the next cycle. The store is indexed by the low log2(`CFG_DEPTH`) bits of the identifier, so identifiers that differ only above those bits share one entry.
- R10: `cfg_word` is zero whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Write one configuration word |
| cfg_wr_cid | input | 10 | Identifier to write (low bits select the entry) |
| cfg_wr_step | input | 2 | Step slot for the word write |
| cfg_wr_word | input | 62 | Configuration word to store |
| cfg_len_wr_en | input | 1 | Write the step count of `cfg_wr_cid` |
| cfg_len_val | input | 2 | Step count minus one |
| ins_valid | input | 1 | Instruction words are present |
| ins_word0 | input | 32 | Head word |
| ins_word1 | input | 32 | Source word |
| dec_valid | output | 1 | One-cycle pulse after acceptance |
| dec_not_custom | output | 1 | Accepted opcode is not the custom opcode |
| dec_raw | output | 32 | Accepted head word, passed through |
| dec_opcode | output | 8 | Opcode field |
| dec_cid | output | 10 | Identifier field |
| dec_mode | output | 2 | Addressing mode |
| dec_rd1 | output | 4 | First destination register |
| dec_rd2 | output | 4 | Second destination register |
| dec_rs | output | 16 | Register numbers of the four sources |
| dec_imm | output | 128 | Zero-extended immediates of the four sources |
| dec_imm_mask | output | 4 | Set bit marks an immediate source |
| busy | output | 1 | Playback in progress; qualifies `cfg_word` |
| done | output | 1 | One-cycle pulse after the last step |
| cfg_step | output | 2 | Current step number |
| cfg_word | output | 62 | Configuration word for this cycle |

## Verification
All results appear one register stage after an edge. The decode fields, `dec_valid` and step 0 become visible in the cycle right after the acceptance edge. Step k follows k cycles later, and `done` appears L+1 cycles after acceptance. The bench drives inputs on the falling edge and samples on the following falling edge. It then walks one sample per cycle through the whole playback, so every value is checked in the cycle it is due. Stimulus held during `busy` is checked on the cycles it overlaps. Back-to-back starts are checked by holding an instruction through the last step and the `done` cycle.

// File: rtl/ci_seq_pkg.sv
// Package: shared widths, field positions, addressing-mode type and the
// immediate-mask helper used by the custom instruction sequencer.
// Assumes 32-bit instruction words and four 8-bit source fields.
package ci_seq_pkg;

    localparam int INS_W     = 32;
    localparam int OPC_W     = 8;
    localparam int CID_W     = 10;
    localparam int MODE_W    = 2;
    localparam int REG_W     = 4;
    localparam int SRC_N     = 4;
    localparam int SRC_W     = 8;
    localparam int CFG_W     = 62;
    localparam int MAX_STEPS = 4;
    localparam int STEP_W    = $clog2(MAX_STEPS);

    // Head-word field positions (lsb of each field)
    localparam int OPC_LSB  = 24;
    localparam int CID_LSB  = 14;
    localparam int MODE_LSB = 12;
    localparam int RD1_LSB  = 8;
    localparam int RD2_LSB  = 0;

    typedef enum logic [MODE_W-1:0] {
        AM_ALL_REG  = 2'd0,
        AM_ONE_IMM  = 2'd1,
        AM_TWO_IMM  = 2'd2,
        AM_THREE_IMM = 2'd3
    } addr_mode_e;

    typedef struct packed {
        logic [OPC_W-1:0]  opcode;
        logic [CID_W-1:0]  cid;
        addr_mode_e        mode;
        logic [REG_W-1:0]  rd1;
        logic [REG_W-1:0]  rd2;
    } ci_head_t;

    // Mode m marks the last m source fields as immediates
    function automatic logic [SRC_N-1:0] imm_mask_f(input addr_mode_e m);
        logic [SRC_N-1:0] r;
        for (int k = 0; k < SRC_N; k++) begin
            r[k] = (k >= SRC_N - int'(m));
        end
        return r;
    endfunction

endpackage

// File: rtl/ci_seq_decode.sv
// Decoder: purely combinational split of the two instruction words into
// head fields and four source operands (register or zero-extended
// immediate). Assumes word0/word1 are stable while being decoded.
module ci_seq_decode
    import ci_seq_pkg::*;
#(
    parameter logic [OPC_W-1:0] CI_OPCODE = 8'hEC
) (
    input  logic [INS_W-1:0]       word0,
    input  logic [INS_W-1:0]       word1,
    output ci_head_t               head,
    output logic                   is_custom,
    output logic [SRC_N*REG_W-1:0] rs_flat,
    output logic [SRC_N*INS_W-1:0] imm_flat,
    output logic [SRC_N-1:0]       imm_mask
);

    logic unused_pad;

    // Purpose: pick the head fields out of the first word
    always_comb begin
        head.opcode = word0[OPC_LSB  +: OPC_W];
        head.cid    = word0[CID_LSB  +: CID_W];
        head.mode   = addr_mode_e'(word0[MODE_LSB +: MODE_W]);
        head.rd1    = word0[RD1_LSB  +: REG_W];
        head.rd2    = word0[RD2_LSB  +: REG_W];
    end

    assign unused_pad = ^word0[RD1_LSB-1:RD2_LSB+REG_W];
    assign is_custom  = (head.opcode == CI_OPCODE);
    assign imm_mask   = imm_mask_f(head.mode);

    // One operand slice per source field; source 1 sits in the top byte
    for (genvar k = 0; k < SRC_N; k++) begin : g_src
        logic [SRC_W-1:0] field;
        assign field = word1[INS_W-1-k*SRC_W -: SRC_W];
        assign rs_flat[k*REG_W +: REG_W] =
            imm_mask[k] ? '0 : field[REG_W-1:0];
        assign imm_flat[k*INS_W +: INS_W] =
            imm_mask[k] ? {{(INS_W-SRC_W){1'b0}}, field} : '0;
    end

endmodule

// File: rtl/ci_seq_cfgmem.sv
// Configuration store: MAX_STEPS words and one step count per entry.
// One write port (word or count), asynchronous read of the count for the
// incoming entry and of the word for the running entry and step.
// Assumes DEPTH is a power of two; contents are not reset.
module ci_seq_cfgmem
    import ci_seq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              len_wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [STEP_W-1:0] wr_step,
    input  logic [CFG_W-1:0]  wr_word,
    input  logic [STEP_W-1:0] wr_len,
    input  logic [IDX_W-1:0]  len_rd_idx,
    output logic [STEP_W-1:0] len_rd,
    input  logic [IDX_W-1:0]  word_rd_idx,
    input  logic [STEP_W-1:0] word_rd_step,
    output logic [CFG_W-1:0]  word_rd
);

    localparam int WORDS = DEPTH * MAX_STEPS;

    logic [CFG_W-1:0]  words [WORDS];
    logic [STEP_W-1:0] lens  [DEPTH];

    // Purpose: store a configuration word into its (entry, step) slot
    always_ff @(posedge clk) begin
        if (wr_en) begin
            words[{wr_idx, wr_step}] <= wr_word;
        end
    end

    // Purpose: store the step count of an entry
    always_ff @(posedge clk) begin
        if (len_wr_en) begin
            lens[wr_idx] <= wr_len;
        end
    end

    assign len_rd  = lens[len_rd_idx];
    assign word_rd = words[{word_rd_idx, word_rd_step}];

endmodule

// File: rtl/ci_seq_stepper.sv
// Stepper: accepts a start while idle, then counts steps 0..len, one per
// cycle, and pulses done the cycle after the last step. Starts seen
// while running are not accepted. Assumes len_in is valid with start.
module ci_seq_stepper
    import ci_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_custom,
    input  logic [STEP_W-1:0] len_in,
    output logic              accept,
    output logic              busy,
    output logic [STEP_W-1:0] step,
    output logic              done
);

    typedef enum logic {ST_IDLE, ST_RUN} st_e;

    st_e               st_q;
    logic [STEP_W-1:0] step_q;
    logic [STEP_W-1:0] len_q;
    logic              done_q;

    assign accept = start && (st_q == ST_IDLE);

    // Purpose: advance the step count and produce the done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            step_q <= '0;
            len_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (accept && is_custom) begin
                        st_q   <= ST_RUN;
                        step_q <= '0;
                        len_q  <= len_in;
                    end
                end
                ST_RUN: begin
                    if (step_q == len_q) begin
                        st_q   <= ST_IDLE;
                        step_q <= '0;
                        done_q <= 1'b1;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (st_q == ST_RUN);
    assign step = step_q;
    assign done = done_q;

endmodule

// File: rtl/ci_seq_top.sv
// Top: decodes a two-word custom instruction, latches its fields on
// acceptance and plays back the stored configuration words of its entry,
// one per cycle. Non-custom opcodes are latched and flagged only.
// Assumes CFG_DEPTH is a power of two no larger than 2**CID_W.
module ci_seq_top
    import ci_seq_pkg::*;
#(
    parameter logic [OPC_W-1:0] CI_OPCODE = 8'hEC,
    parameter int               CFG_DEPTH = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr_en,
    input  logic [CID_W-1:0]       cfg_wr_cid,
    input  logic [STEP_W-1:0]      cfg_wr_step,
    input  logic [CFG_W-1:0]       cfg_wr_word,
    input  logic                   cfg_len_wr_en,
    input  logic [STEP_W-1:0]      cfg_len_val,
    input  logic                   ins_valid,
    input  logic [INS_W-1:0]       ins_word0,
    input  logic [INS_W-1:0]       ins_word1,
    output logic                   dec_valid,
    output logic                   dec_not_custom,
    output logic [INS_W-1:0]       dec_raw,
    output logic [OPC_W-1:0]       dec_opcode,
    output logic [CID_W-1:0]       dec_cid,
    output logic [MODE_W-1:0]      dec_mode,
    output logic [REG_W-1:0]       dec_rd1,
    output logic [REG_W-1:0]       dec_rd2,
    output logic [SRC_N*REG_W-1:0] dec_rs,
    output logic [SRC_N*INS_W-1:0] dec_imm,
    output logic [SRC_N-1:0]       dec_imm_mask,
    output logic                   busy,
    output logic                   done,
    output logic [STEP_W-1:0]      cfg_step,
    output logic [CFG_W-1:0]       cfg_word
);

    localparam int IDX_W = $clog2(CFG_DEPTH);

    ci_head_t               head;
    logic                   is_custom;
    logic [SRC_N*REG_W-1:0] rs_flat;
    logic [SRC_N*INS_W-1:0] imm_flat;
    logic [SRC_N-1:0]       imm_mask;
    logic                   accept;
    logic                   run_busy;
    logic [STEP_W-1:0]      run_step;
    logic [STEP_W-1:0]      entry_len;
    logic [CFG_W-1:0]       entry_word;
    logic [IDX_W-1:0]       run_idx_q;
    logic                   unused_wr_hi;

    ci_head_t               head_q;
    logic                   valid_q;
    logic                   notc_q;
    logic [INS_W-1:0]       raw_q;
    logic [SRC_N*REG_W-1:0] rs_q;
    logic [SRC_N*INS_W-1:0] imm_q;
    logic [SRC_N-1:0]       mask_q;

    assign unused_wr_hi = ^cfg_wr_cid[CID_W-1:IDX_W];

    ci_seq_decode #(.CI_OPCODE(CI_OPCODE)) u_dec (
        .word0     (ins_word0),
        .word1     (ins_word1),
        .head      (head),
        .is_custom (is_custom),
        .rs_flat   (rs_flat),
        .imm_flat  (imm_flat),
        .imm_mask  (imm_mask)
    );

    ci_seq_cfgmem #(.DEPTH(CFG_DEPTH), .IDX_W(IDX_W)) u_mem (
        .clk          (clk),
        .wr_en        (cfg_wr_en),
        .len_wr_en    (cfg_len_wr_en),
        .wr_idx       (cfg_wr_cid[IDX_W-1:0]),
        .wr_step      (cfg_wr_step),
        .wr_word      (cfg_wr_word),
        .wr_len       (cfg_len_val),
        .len_rd_idx   (head.cid[IDX_W-1:0]),
        .len_rd       (entry_len),
        .word_rd_idx  (run_idx_q),
        .word_rd_step (run_step),
        .word_rd      (entry_word)
    );

    ci_seq_stepper u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (ins_valid),
        .is_custom (is_custom),
        .len_in    (entry_len),
        .accept    (accept),
        .busy      (run_busy),
        .step      (run_step),
        .done      (done)
    );

    // Purpose: hold the decoded fields of the last accepted instruction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q   <= 1'b0;
            notc_q    <= 1'b0;
            raw_q     <= '0;
            head_q    <= '0;
            rs_q      <= '0;
            imm_q     <= '0;
            mask_q    <= '0;
            run_idx_q <= '0;
        end else begin
            valid_q <= accept;
            if (accept) begin
                notc_q <= !is_custom;
                raw_q  <= ins_word0;
                head_q <= head;
                rs_q   <= rs_flat;
                imm_q  <= imm_flat;
                mask_q <= imm_mask;
                if (is_custom) begin
                    run_idx_q <= head.cid[IDX_W-1:0];
                end
            end
        end
    end

    assign dec_valid      = valid_q;
    assign dec_not_custom = notc_q;
    assign dec_raw        = raw_q;
    assign dec_opcode     = head_q.opcode;
    assign dec_cid        = head_q.cid;
    assign dec_mode       = head_q.mode;
    assign dec_rd1        = head_q.rd1;
    assign dec_rd2        = head_q.rd2;
    assign dec_rs         = rs_q;
    assign dec_imm        = imm_q;
    assign dec_imm_mask   = mask_q;
    assign busy           = run_busy;
    assign cfg_step       = run_step;
    assign cfg_word       = run_busy ? entry_word : '0;

endmodule

// File: rtl/ci_seq_chk.sv
// Checker: temporal properties of the sequencer, observed at its ports.
// Bound into every ci_seq_top instance.
module ci_seq_chk
    import ci_seq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ins_valid,
    input logic              busy,
    input logic              done,
    input logic              dec_valid,
    input logic              dec_not_custom,
    input logic [STEP_W-1:0] cfg_step,
    input logic [CFG_W-1:0]  cfg_word,
    input logic [CID_W-1:0]  dec_cid,
    input logic [OPC_W-1:0]  dec_opcode,
    input logic [SRC_N-1:0]  dec_imm_mask
);

    AST_FIRST_STEP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> cfg_step == '0); // R4

    AST_STEP_INCREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_step != '0) |-> ($past(busy) && cfg_step == $past(cfg_step) + 1'b1)); // R4

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5

    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy)); // R5

    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ins_valid) |=> (!dec_valid && $stable(dec_cid) && $stable(dec_opcode))); // R6

    AST_PASSTHRU_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_not_custom) |-> !busy); // R7

    AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_imm_mask inside {4'b0000, 4'b1000, 4'b1100, 4'b1110}); // R3

    AST_IDLE_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cfg_word == '0); // R10

endmodule

bind ci_seq_top ci_seq_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .ins_valid      (ins_valid),
    .busy           (busy),
    .done           (done),
    .dec_valid      (dec_valid),
    .dec_not_custom (dec_not_custom),
    .cfg_step       (cfg_step),
    .cfg_word       (cfg_word),
    .dec_cid        (dec_cid),
    .dec_opcode     (dec_opcode),
    .dec_imm_mask   (dec_imm_mask)
);

// File: tb/ci_seq_top_tb_top.sv
`timescale 1ns/1ps
// Bench: loads the configuration store, walks a vector table of
// instructions, then runs directed cases for busy-ignore, back-to-back
// starts, store rewrites, aliasing and reset during playback.
module ci_seq_top_tb_top;

    localparam logic [7:0] CI_OP = 8'hEC;
    localparam int DEPTH = 64;
    localparam int NVEC = 9;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         cfg_wr_en, cfg_len_wr_en;
    logic [9:0]   cfg_wr_cid;
    logic [1:0]   cfg_wr_step, cfg_len_val;
    logic [61:0]  cfg_wr_word;
    logic         ins_valid;
    logic [31:0]  ins_word0, ins_word1;
    logic         dec_valid, dec_not_custom, busy, done;
    logic [31:0]  dec_raw;
    logic [7:0]   dec_opcode;
    logic [9:0]   dec_cid;
    logic [1:0]   dec_mode, cfg_step;
    logic [3:0]   dec_rd1, dec_rd2, dec_imm_mask;
    logic [15:0]  dec_rs;
    logic [127:0] dec_imm;
    logic [61:0]  cfg_word;

    int tests = 0;
    int fails = 0;

    logic [61:0] mdl_word [DEPTH][4];
    logic [1:0]  mdl_len  [DEPTH];
    logic [68:0] v;

    // Vector: {word0, word1, expected immediate mask, is-custom}
    // word0 = {opcode, cid, mode, rd1, 4'h0, rd2}
    localparam logic [68:0] VECS [NVEC] = '{
        {CI_OP, 10'd5,    2'd0, 4'd3,  4'h0, 4'd9,  32'h1A2B3C4D, 4'b0000, 1'b1},
        {CI_OP, 10'd6,    2'd1, 4'd1,  4'h0, 4'd2,  32'hF1E2D3C4, 4'b1000, 1'b1},
        {CI_OP, 10'd11,   2'd2, 4'd15, 4'h0, 4'd0,  32'h0807FF80, 4'b1100, 1'b1},
        {CI_OP, 10'd12,   2'd3, 4'd7,  4'h0, 4'd8,  32'h55AA33CC, 4'b1110, 1'b1},
        {CI_OP, 10'd69,   2'd1, 4'd4,  4'h0, 4'd5,  32'h12345678, 4'b1000, 1'b1},
        {8'h13, 10'd100,  2'd2, 4'd2,  4'h0, 4'd6,  32'h00000000, 4'b1100, 1'b0},
        {CI_OP, 10'd1023, 2'd0, 4'd14, 4'h0, 4'd13, 32'hDEADBEEF, 4'b0000, 1'b1},
        {CI_OP, 10'd0,    2'd3, 4'd10, 4'h0, 4'd11, 32'h00000001, 4'b1110, 1'b1},
        {8'hED, 10'd7,    2'd0, 4'd1,  4'h0, 4'd1,  32'h9ABCDEF0, 4'b0000, 1'b0}
    };

    ci_seq_top #(.CI_OPCODE(CI_OP), .CFG_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_cid(cfg_wr_cid), .cfg_wr_step(cfg_wr_step),
        .cfg_wr_word(cfg_wr_word), .cfg_len_wr_en(cfg_len_wr_en), .cfg_len_val(cfg_len_val),
        .ins_valid(ins_valid), .ins_word0(ins_word0), .ins_word1(ins_word1),
        .dec_valid(dec_valid), .dec_not_custom(dec_not_custom), .dec_raw(dec_raw),
        .dec_opcode(dec_opcode), .dec_cid(dec_cid), .dec_mode(dec_mode),
        .dec_rd1(dec_rd1), .dec_rd2(dec_rd2), .dec_rs(dec_rs), .dec_imm(dec_imm),
        .dec_imm_mask(dec_imm_mask), .busy(busy), .done(done),
        .cfg_step(cfg_step), .cfg_word(cfg_word)
    );

    always #2 clk = ~clk;

    function automatic logic [61:0] pat(input int idx, input int s);
        return {30'(idx * 977 + s * 13 + 1), ~32'(idx * 4 + s)};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [127:0] got, input logic [127:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    task automatic wr_word(input int idx, input int s, input logic [61:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_len_wr_en = 1'b0;
        cfg_wr_cid = 10'(idx); cfg_wr_step = 2'(s); cfg_wr_word = d;
        mdl_word[idx % DEPTH][s] = d;
    endtask

    task automatic wr_len(input int idx, input logic [1:0] l);
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_len_wr_en = 1'b1;
        cfg_wr_cid = 10'(idx); cfg_len_val = l;
        mdl_len[idx % DEPTH] = l;
    endtask

    task automatic wr_done();
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_len_wr_en = 1'b0;
    endtask

    // Check the decode outputs against the requirement-level field layout
    task automatic chk_decode(input logic [31:0] w0, input logic [31:0] w1,
                              input logic [3:0] mask, input logic custom);
        logic [15:0]  ers;
        logic [127:0] eimm;
        logic [7:0]   fld;
        ers = '0; eimm = '0;
        for (int n = 0; n < 4; n++) begin
            fld = w1[31 - 8*n -: 8];
            if (mask[n]) eimm[32*n +: 32] = {24'h0, fld};
            else         ers[4*n +: 4] = fld[3:0];
        end
        chk("R2", "dec_valid", 128'(dec_valid), 128'(1));
        chk("R2", "opcode", 128'(dec_opcode), 128'(w0[31:24]));
        chk("R2", "cid", 128'(dec_cid), 128'(w0[23:14]));
        chk("R2", "mode", 128'(dec_mode), 128'(w0[13:12]));
        chk("R2", "rd1/rd2", 128'({dec_rd1, dec_rd2}), 128'({w0[11:8], w0[3:0]}));
        chk("R2", "raw", 128'(dec_raw), 128'(w0));
        chk("R3", "imm mask", 128'(dec_imm_mask), 128'(mask));
        chk("R3", "source regs", 128'(dec_rs), 128'(ers));
        chk("R3", "source imms", dec_imm, eimm);
        chk("R7", "not_custom flag", 128'(dec_not_custom), 128'(!custom));
    endtask

    // Check playback from step 0 (current cycle) through the done pulse
    task automatic chk_run(input int idx);
        int l;
        l = int'(mdl_len[idx]);
        for (int k = 0; k <= l; k++) begin
            chk("R5", "busy in step", 128'(busy), 128'(1));
            chk("R4", "step number", 128'(cfg_step), 128'(k));
            chk("R4", "config word", 128'(cfg_word), 128'(mdl_word[idx][k]));
            chk("R5", "done low in step", 128'(done), 128'(0));
            @(negedge clk);
        end
        chk("R5", "done pulse", 128'(done), 128'(1));
        chk("R5", "busy low at done", 128'(busy), 128'(0));
        chk("R10", "idle word zero", 128'(cfg_word), 128'(0));
    endtask

    task automatic run_ci(input logic [31:0] w0, input logic [31:0] w1,
                          input logic [3:0] mask, input logic custom);
        @(negedge clk);
        ins_valid = 1'b1; ins_word0 = w0; ins_word1 = w1;
        @(negedge clk);
        ins_valid = 1'b0;
        chk_decode(w0, w1, mask, custom);
        if (custom) begin
            chk_run(int'(w0[19:14]));           // R9: low identifier bits
            @(negedge clk);
            chk("R5", "done one cycle", 128'(done), 128'(0));
        end else begin
            chk("R7", "no playback", 128'({busy, done}), 128'(0));
            chk("R10", "word zero", 128'(cfg_word), 128'(0));
            @(negedge clk);
            chk("R7", "still idle", 128'({busy, done, dec_valid}), 128'(0));
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        fails++; tests++;
        $display("FAIL R5 watchdog actual=expired expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ins_valid = 1'b0; ins_word0 = '0; ins_word1 = '0;
        cfg_wr_en = 1'b0; cfg_len_wr_en = 1'b0; cfg_wr_cid = '0;
        cfg_wr_step = '0; cfg_wr_word = '0; cfg_len_val = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "reset busy/done/valid/notc", 128'({busy, done, dec_valid, dec_not_custom}), 128'(0));
        chk("R1", "reset word", 128'(cfg_word), 128'(0));
        rst_n = 1'b1;

        for (int i = 0; i < DEPTH; i++) begin
            for (int s = 0; s < 4; s++) wr_word(i, s, pat(i, s));
            wr_len(i, 2'(i % 4));
        end
        wr_done();

        // Vector table walk (R2, R3, R4, R5, R7, R9 aliasing via cid 69/1023)
        for (int i = 0; i < NVEC; i++) begin
            v = VECS[i];
            run_ci(v[68:37], v[36:5], v[4:1], v[0]);
        end

        // R6: instruction held while busy is ignored
        @(negedge clk);
        ins_valid = 1'b1; ins_word0 = {CI_OP, 10'd11, 2'd0, 4'd1, 4'h0, 4'd1}; ins_word1 = '0;
        @(negedge clk);
        ins_word0 = {8'h21, 10'd5, 2'd1, 4'd2, 4'h0, 4'd2};
        for (int k = 0; k < 4; k++) begin
            chk("R6", "step continues", 128'(cfg_step), 128'(k));
            chk("R6", "cid held", 128'(dec_cid), 128'(11));
            if (k == 3) ins_valid = 1'b0;
            @(negedge clk);
            if (k < 3) chk("R6", "no new valid", 128'(dec_valid), 128'(0));
        end
        chk("R6", "done after ignored start", 128'({done, dec_cid}), 128'({1'b1, 10'd11}));

        // R8: start held through last step and the done cycle
        @(negedge clk);
        ins_valid = 1'b1; ins_word0 = {CI_OP, 10'd12, 2'd0, 4'd1, 4'h0, 4'd1};
        @(negedge clk);
        ins_word0 = {CI_OP, 10'd5, 2'd0, 4'd3, 4'h0, 4'd4};
        chk("R8", "first run step", 128'({busy, cfg_step}), 128'({1'b1, 2'd0}));
        @(negedge clk);
        chk("R8", "done cycle, old cid", 128'({done, busy, dec_cid}), 128'({1'b1, 1'b0, 10'd12}));
        @(negedge clk);
        ins_valid = 1'b0;
        chk("R8", "second accepted", 128'({dec_valid, dec_cid}), 128'({1'b1, 10'd5}));
        chk_run(5);

        // R9: rewrite an entry, visible on the next use
        wr_word(7, 1, 62'h2A5A5A5A_0F0F0F0);
        wr_len(7, 2'd1);
        wr_done();
        run_ci({CI_OP, 10'd7, 2'd0, 4'd0, 4'h0, 4'd0}, 32'h01020304, 4'b0000, 1'b1);
        // R9: write through an alias identifier lands in the shared entry
        wr_word(64 + 9, 0, 62'h1111_2222_3333_444);
        wr_done();
        run_ci({CI_OP, 10'd9, 2'd2, 4'd0, 4'h0, 4'd0}, 32'h01020304, 4'b1100, 1'b1);

        // R1: reset during playback abandons it, store survives
        @(negedge clk);
        ins_valid = 1'b1; ins_word0 = {CI_OP, 10'd11, 2'd0, 4'd1, 4'h0, 4'd1};
        @(negedge clk);
        ins_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "reset mid-run outputs", 128'({busy, done, dec_valid, dec_not_custom}), 128'(0));
        chk("R1", "reset mid-run word", 128'(cfg_word), 128'(0));
        rst_n = 1'b1;
        run_ci({CI_OP, 10'd11, 2'd1, 4'd5, 4'h0, 4'd6}, 32'hA0B0C0D0, 4'b1000, 1'b1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule